// File: doc/BRIEF.md
# I2C Misplaced START/STOP Bus-Error Detector

This block watches the SCL and SDA lines of an I2C bus and keeps track of how far the current frame has progressed. It counts the bits of each byte: eight data bits and then the acknowledge bit. A START or STOP condition is allowed only in three places: while the bus is idle, right after a START, or during the high phase of the first bit of a byte. A START or STOP in any other bit position is a framing violation.

A violation counts only when the local controller takes part in the transfer, which means it is the active master or an addressed slave. When it counts, the block emits a one-cycle error pulse. That pulse tells the controller to fall back to the not-addressed slave mode. At the same time the block loads status code 00H, raises the interrupt flag and requests release of both bus lines. Status, flag and release request stay in place until the interrupt is cleared. After the clear, status returns to the "nothing pending" code F8H.

The line inputs pass through a synchronizer inside the block. The involvement indications come from the controller's own state machine.

Top module: `i2c_berr_det`

## Requirements
- R1: A START is SDA going 1→0 while SCL stays 1. A STOP is SDA going 0→1 while SCL stays 1. Both are judged on line samples that have passed a two-stage synchronizer.
- R2: Inside a frame, bit positions are counted on SCL falling edges, nine per byte (positions 0 to 7 for data, position 8 for the acknowledge). The count wraps to 0 after the acknowledge. The SCL fall that ends a START is not counted.
- R3: A START or STOP during the high phase of bit positions 1 to 7 of an address or data byte is a bus error.
- R4: A START or STOP during the high phase of the acknowledge bit (position 8) is a bus error.
- R5: A START or STOP is legal on an idle bus, between a START and the next SCL fall, and during the high phase of position 0. A legal condition raises no error, and this includes a repeated START after an acknowledge.
- R6: When neither is_master nor is_addressed is 1, a misplaced condition has no effect: bus_err, status, irq and release_lines all stay unchanged.
- R7: An error that counts gives a one-cycle bus_err pulse. In the same cycle status becomes 8'h00, irq becomes 1 and release_lines becomes 1.
- R8: irq, status 8'h00 and release_lines hold until irq_clr is seen. After that irq is 0, release_lines is 0 and status is 8'hF8.
- R9: Every START, legal or not, restarts the bit count at the start of a frame. Every STOP returns the tracker to idle. The frame that follows an error is therefore judged from a clean count.
- R10: After reset, status is 8'hF8, and irq, release_lines and bus_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| is_master | input | 1 | Controller is the active master |
| is_addressed | input | 1 | Controller is an addressed slave |
| irq_clr | input | 1 | Clears the interrupt flag and returns status to F8H |
| bus_err | output | 1 | One-cycle pulse: fall back to the not-addressed slave mode |
| status | output | 8 | Status code: 00H after a bus error, F8H otherwise |
| irq | output | 1 | Interrupt flag |
| release_lines | output | 1 | Request to release SDA and SCL |

## Verification
Suppose the bit position is off by one, or the fall that ends a START is counted. The symptom at the ports is an error pulse that should not be there, or one that is missing. Either shows up on the START or STOP that follows the miscount, no more than three clocks after the SDA edge that forms the condition. A frame with nine bits and then a STOP must stay silent. A frame with eight bits and then a START must fail.

A wrong involvement gate or a wrong response register shows at once in the status, irq and release_lines values sampled with the pulse. A wrong clear path shows when those outputs either fail to hold across idle cycles or fail to return to F8H after irq_clr.

// File: rtl/i2c_berr_pkg.sv
package i2c_berr_pkg;

    localparam int STATUS_W = 8;
    localparam logic [STATUS_W-1:0] STAT_BUS_ERR = 8'h00;
    localparam logic [STATUS_W-1:0] STAT_NONE    = 8'hF8;

    typedef enum logic [1:0] {
        TRK_IDLE  = 2'd0,
        TRK_HOLD  = 2'd1,
        TRK_FRAME = 2'd2
    } trk_state_e;

    typedef struct packed {
        logic                bus_err;
        logic                irq;
        logic                release_lines;
        logic [STATUS_W-1:0] status;
    } resp_t;

endpackage

// File: rtl/i2c_berr_lines.sv
module i2c_berr_lines #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_fall
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_old;
        logic                   sda_old;
    } ln_t;

    ln_t ln_d, ln_q;
    logic scl_lvl, sda_lvl;

    assign scl_lvl = ln_q.scl_sh[SYNC_STAGES-1];
    assign sda_lvl = ln_q.sda_sh[SYNC_STAGES-1];

    always_comb begin
        ln_d = ln_q;
        ln_d.scl_sh[0] = scl_in;
        ln_d.sda_sh[0] = sda_in;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            ln_d.scl_sh[i] = ln_q.scl_sh[i-1];
            ln_d.sda_sh[i] = ln_q.sda_sh[i-1];
        end
        ln_d.scl_old = scl_lvl;
        ln_d.sda_old = sda_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '1;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign start_ev = scl_lvl & ln_q.scl_old & ln_q.sda_old & ~sda_lvl;
    assign stop_ev  = scl_lvl & ln_q.scl_old & ~ln_q.sda_old & sda_lvl;
    assign scl_fall = ln_q.scl_old & ~scl_lvl;
endmodule

// File: rtl/i2c_berr_track.sv
module i2c_berr_track
    import i2c_berr_pkg::*;
#(
    parameter int BITS_PER_BYTE = 8,
    localparam int LAST_POS = BITS_PER_BYTE,
    localparam int POS_W    = $clog2(LAST_POS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic             scl_fall,
    output logic             illegal_ev,
    output logic [POS_W-1:0] bit_pos
);
    typedef struct packed {
        trk_state_e       state;
        logic [POS_W-1:0] pos;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (start_ev) begin
            trk_d.state = TRK_HOLD;
            trk_d.pos   = '0;
        end else if (stop_ev) begin
            trk_d.state = TRK_IDLE;
            trk_d.pos   = '0;
        end else if (scl_fall) begin
            case (trk_q.state)
                TRK_HOLD: begin
                    trk_d.state = TRK_FRAME;
                    trk_d.pos   = '0;
                end
                TRK_FRAME: begin
                    if (trk_q.pos == POS_W'(LAST_POS)) begin
                        trk_d.pos = '0;
                    end else begin
                        trk_d.pos = trk_q.pos + 1'b1;
                    end
                end
                default: trk_d.pos = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{state: TRK_IDLE, pos: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign illegal_ev = (start_ev | stop_ev) & (trk_q.state == TRK_FRAME)
                        & (trk_q.pos != '0);
    assign bit_pos    = trk_q.pos;
endmodule

// File: rtl/i2c_berr_resp.sv
module i2c_berr_resp
    import i2c_berr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                illegal_ev,
    input  logic                involved,
    input  logic                irq_clr,
    output logic                bus_err,
    output logic                irq,
    output logic                release_lines,
    output logic [STATUS_W-1:0] status
);
    resp_t rs_d, rs_q;
    logic  err_now;

    assign err_now = illegal_ev & involved;

    always_comb begin
        rs_d = rs_q;
        rs_d.bus_err = err_now;
        if (err_now) begin
            rs_d.irq           = 1'b1;
            rs_d.release_lines = 1'b1;
            rs_d.status        = STAT_BUS_ERR;
        end else if (irq_clr) begin
            rs_d.irq           = 1'b0;
            rs_d.release_lines = 1'b0;
            rs_d.status        = STAT_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '{bus_err: 1'b0, irq: 1'b0, release_lines: 1'b0, status: STAT_NONE};
        end else begin
            rs_q <= rs_d;
        end
    end

    assign bus_err       = rs_q.bus_err;
    assign irq           = rs_q.irq;
    assign release_lines = rs_q.release_lines;
    assign status        = rs_q.status;
endmodule

// File: rtl/i2c_berr_det.sv
module i2c_berr_det
    import i2c_berr_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int BITS_PER_BYTE = 8,
    localparam int POS_W = $clog2(BITS_PER_BYTE + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic                is_master,
    input  logic                is_addressed,
    input  logic                irq_clr,
    output logic                bus_err,
    output logic [STATUS_W-1:0] status,
    output logic                irq,
    output logic                release_lines
);
    logic             start_ev, stop_ev, scl_fall;
    logic             illegal_ev;
    logic [POS_W-1:0] bit_pos;

    i2c_berr_lines #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .scl_fall (scl_fall)
    );

    i2c_berr_track #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .scl_fall   (scl_fall),
        .illegal_ev (illegal_ev),
        .bit_pos    (bit_pos)
    );

    i2c_berr_resp u_resp (
        .clk           (clk),
        .rst_n         (rst_n),
        .illegal_ev    (illegal_ev),
        .involved      (is_master | is_addressed),
        .irq_clr       (irq_clr),
        .bus_err       (bus_err),
        .irq           (irq),
        .release_lines (release_lines),
        .status        (status)
    );
endmodule

// File: rtl/i2c_berr_chk.sv
module i2c_berr_chk
    import i2c_berr_pkg::*;
#(
    parameter int BITS_PER_BYTE = 8,
    localparam int POS_W = $clog2(BITS_PER_BYTE + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                is_master,
    input logic                is_addressed,
    input logic                irq_clr,
    input logic                bus_err,
    input logic [STATUS_W-1:0] status,
    input logic                irq,
    input logic                release_lines,
    input logic [POS_W-1:0]    bit_pos
);
    // R7
    err_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (status == STAT_BUS_ERR) && irq && release_lines);

    // R7
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !bus_err);

    // R6
    err_involved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(is_master || is_addressed));

    // R5
    err_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bit_pos) != '0);

    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(irq_clr));

    // R8
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (status == STAT_NONE) && !release_lines);

    // R2
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_pos <= POS_W'(BITS_PER_BYTE));
endmodule

bind i2c_berr_det i2c_berr_chk #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .is_master     (is_master),
    .is_addressed  (is_addressed),
    .irq_clr       (irq_clr),
    .bus_err       (bus_err),
    .status        (status),
    .irq           (irq),
    .release_lines (release_lines),
    .bit_pos       (bit_pos)
);

// File: tb/i2c_berr_det_tb.sv
module i2c_berr_det_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD_CYC   = 4;
    localparam int WDOG_CYC   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1, sda_in = 1'b1;
    logic       is_master = 1'b0, is_addressed = 1'b0, irq_clr = 1'b0;
    logic       bus_err, irq, release_lines;
    logic [7:0] status;

    int n_checks = 0;
    int n_fail   = 0;
    int n_unexp  = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [7:0] status;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    i2c_berr_det u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .is_master(is_master), .is_addressed(is_addressed), .irq_clr(irq_clr),
        .bus_err(bus_err), .status(status), .irq(irq), .release_lines(release_lines)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 0, 1);
        finish_run();
    end

    // monitor: pops expectations as error pulses appear
    always @(negedge clk) begin
        if (rst_n && bus_err) begin
            if (exp_q.size() == 0) begin
                n_unexp++;
                check(1'b0, "R6", "unexpected bus_err pulse", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(status == e.status && irq && release_lines, e.req,
                      "status/irq/release with pulse",
                      {22'd0, irq, release_lines, status}, {22'd0, 2'b11, e.status});
            end
        end
    end

    task automatic expect_err(input string req);
        exp_t e;
        e.status = 8'h00;
        e.req    = req;
        exp_q.push_back(e);
    endtask

    task automatic put(input logic c, input logic d);
        @(negedge clk);
        scl_in = c;
        sda_in = d;
        repeat (HOLD_CYC) @(negedge clk);
    endtask

    task automatic do_start();  put(1, 1); put(1, 0); put(0, 0); endtask
    task automatic do_bit(input logic b); put(0, b); put(1, b); put(0, b); endtask
    task automatic do_stop();   put(0, 0); put(1, 0); put(1, 1); endtask
    task automatic do_rstart(); put(0, 1); put(1, 1); put(1, 0); put(0, 0); endtask
    task automatic do_bits(input int n);
        for (int i = 0; i < n; i++) do_bit(i[0]);
    endtask

    task automatic scenario_done(input string req, input int unexp_before);
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0 && n_unexp == unexp_before, req,
              "pending or extra errors", exp_q.size() + n_unexp - unexp_before, 0);
        exp_q.delete();
    endtask

    task automatic check_idle_outputs(input string req);
        check(status == 8'hF8 && !irq && !release_lines, req, "quiet outputs",
              {23'd0, irq, status}, {23'd0, 1'b0, 8'hF8});
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int u;
        repeat (3) @(negedge clk);
        check(status == 8'hF8 && !irq && !release_lines && !bus_err, "R10",
              "reset outputs", {22'd0, irq, release_lines, status}, {24'd0, 8'hF8});
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle_outputs("R10");

        // legal frames: full byte, repeated START after ack, STOP after ack (R5, R2)
        is_master = 1'b1;
        u = n_unexp;
        do_start(); do_bits(9); do_rstart(); do_bits(9); do_stop();
        scenario_done("R5", u);
        check_idle_outputs("R2");

        // START followed at once by STOP is legal (R5)
        u = n_unexp;
        do_start(); put(1, 0); put(1, 1);
        scenario_done("R5", u);

        // STOP in the middle of a byte, master (R3, R1)
        u = n_unexp;
        do_start(); do_bits(4);
        put(0, 0); put(1, 0);
        expect_err("R3");
        put(1, 1);
        scenario_done("R1", u);
        check(status == 8'h00 && irq && release_lines, "R7", "outputs after error",
              {23'd0, irq, status}, {23'd0, 1'b1, 8'h00});
        repeat (20) @(negedge clk);
        check(status == 8'h00 && irq && release_lines, "R8", "outputs held",
              {23'd0, irq, status}, {23'd0, 1'b1, 8'h00});
        clear_irq();
        check_idle_outputs("R8");

        // START during the acknowledge bit, addressed slave (R4), then fresh frame (R9)
        is_master = 1'b0; is_addressed = 1'b1;
        u = n_unexp;
        do_start(); do_bits(8);
        put(0, 1); put(1, 1);
        expect_err("R4");
        put(1, 0); put(0, 0);
        do_bits(9); do_stop();
        scenario_done("R9", u);
        check(irq && status == 8'h00, "R4", "flag after ack error",
              {23'd0, irq, status}, {23'd0, 1'b1, 8'h00});
        clear_irq();
        check_idle_outputs("R8");

        // STOP at bit position 1 (R3)
        u = n_unexp;
        do_start(); do_bits(1);
        put(0, 0); put(1, 0);
        expect_err("R3");
        put(1, 1);
        scenario_done("R3", u);
        clear_irq();

        // not involved: misplaced STOP and START have no effect (R6)
        is_addressed = 1'b0;
        u = n_unexp;
        do_start(); do_bits(4); put(0, 0); put(1, 0); put(1, 1);
        scenario_done("R6", u);
        check_idle_outputs("R6");
        do_start(); do_bits(8); put(0, 1); put(1, 1); put(1, 0); put(0, 0);
        do_bits(9); do_stop();
        check_idle_outputs("R6");

        // after ignored errors, involved frame judged fresh (R9)
        is_master = 1'b1;
        u = n_unexp;
        do_start(); do_bits(9); do_stop();
        scenario_done("R9", u);

        finish_run();
    end
endmodule